// File: doc/BRIEF.md
# Folded-Symmetry Systolic FIR Filter

This block is an eight-tap FIR filter whose coefficients mirror around the centre. Four distinct coefficient values are set as compile-time parameters. Every clock it accepts one signed sample with a valid strobe. Every clock it returns one full-precision signed result with a matching strobe. The pipeline runs freely. A sample whose strobe is low enters the filter as zero, so the output stream is the convolution of the coefficient set with the gated input stream.

The two samples that share a coefficient are added first, and only the sum is multiplied. This gives four multipliers instead of eight. The four multiply-accumulate stages form a systolic chain, which replaces a direct-form adder tree. Between stages, the forward sample chain carries two registers per hop and the partial sum carries one. The mirrored sample comes from an eight-deep shift register fed by the registered input. The result appears a fixed eight cycles after its newest contributing sample.

Top module: `fir_sym8`

## Requirements
- R1: In the cycle after any clock edge with `rst` high, `out_data` is zero and `out_valid` is low. Reset clears all sample history, so later outputs treat pre-reset samples as zero.
- R2: A single valid sample of value 1 accepted at edge n, with zero samples around it, makes `out_data` after edges n+8 to n+15 read H0, H1, H2, H3, H3, H2, H1, H0 in that order, and zero after edges n+1 to n+7 and n+16 onward.
- R3: After edge t, `out_data` equals the sum over k = 0 to 7 of c_k times x(t-8-k). Here x(e) is the gated input at edge e, c_k = H_k for k < 4 and c_k = H_(7-k) otherwise. The result is a two's complement value in `ACC_W` bits, with no rounding, and a new sample is taken every cycle.
- R4: `out_valid` after edge t equals `in_valid` at edge t-8.
- R5: A sample presented with `in_valid` low enters the filter as zero, whatever `in_data` holds.
- R6: Full-scale inputs (-32768 and 32767) combined with coefficients as large as -131072 give exact results without wrap-around in the default `ACC_W` of 38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears every register |
| in_valid | input | 1 | Marks `in_data` as a real sample; when low the sample is taken as zero |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | `in_valid` delayed by the eight-cycle latency |
| out_data | output | ACC_W | Signed full-precision filter output |

## Verification
A single unit impulse isolates each coefficient in its own output cycle. This shows whether the mirror pairing and the tap order are right. Back-to-back random samples test the systolic alignment of every pair at full rate. Random gaps in the strobe, with non-zero data under a low strobe, separate gating errors from strobe-delay errors. Sign-matched full-scale patterns and a constant most-negative run expose any narrowing in the pre-adder, product or accumulator, and a reset in mid-stream shows whether history is cleared.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

   // Number of coefficient pairs (distinct coefficients) in the folded filter.
   localparam int unsigned PAIRS = 4;
   // Number of taps of the unfolded filter.
   localparam int unsigned TAPS  = 2 * PAIRS;

   // Smallest accumulator width that holds every result without wrap:
   // pre-add grows one bit, the product adds the coefficient width,
   // and summing PAIRS products adds clog2(PAIRS) bits.
   function automatic int unsigned min_acc_w(input int unsigned data_w,
                                             input int unsigned coef_w);
      return data_w + 1 + coef_w + $clog2(PAIRS);
   endfunction

endpackage

// File: rtl/fir_sym_shreg.sv
module fir_sym_shreg #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stg [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end

         assign q = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/fir_sym_stage.sv
module fir_sym_stage #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COEF_W = 18,
   parameter int unsigned ACC_W  = 38,
   parameter logic signed [COEF_W-1:0] COEF = '0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] fwd_in,
   input  logic signed [DATA_W-1:0] mir_in,
   input  logic signed [ACC_W-1:0]  acc_in,
   output logic signed [DATA_W-1:0] fwd_out,
   output logic signed [ACC_W-1:0]  acc_out
);

   localparam int unsigned PRE_W  = DATA_W + 1;
   localparam int unsigned PROD_W = PRE_W + COEF_W;

   logic signed [DATA_W-1:0] fwd_a, fwd_b;   // two-register forward hop
   logic signed [PRE_W-1:0]  pre_q;
   logic signed [PROD_W-1:0] prod_q;
   logic signed [ACC_W-1:0]  acc_q;

   logic signed [PRE_W-1:0]  a_ext, b_ext;
   logic signed [ACC_W-1:0]  prod_ext;

   assign a_ext    = {fwd_a[DATA_W-1], fwd_a};
   assign b_ext    = {mir_in[DATA_W-1], mir_in};
   assign prod_ext = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         fwd_a  <= '0;
         fwd_b  <= '0;
         pre_q  <= '0;
         prod_q <= '0;
         acc_q  <= '0;
      end else begin
         fwd_a  <= fwd_in;
         fwd_b  <= fwd_a;
         pre_q  <= a_ext + b_ext;
         prod_q <= pre_q * COEF;
         acc_q  <= acc_in + prod_ext;
      end
   end

   assign fwd_out = fwd_b;
   assign acc_out = acc_q;

   // R3: forward samples reach the next stage exactly two cycles later,
   // which keeps data and partial sums aligned in the cascade.
   a_r3_fwd_skew: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (fwd_out == $past(fwd_in, 2)));

endmodule

// File: rtl/fir_sym8.sv
module fir_sym8 #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COEF_W = 18,
   parameter int unsigned ACC_W  = 38,
   parameter logic signed [COEF_W-1:0] H0 = -18'sd1024,
   parameter logic signed [COEF_W-1:0] H1 =  18'sd4096,
   parameter logic signed [COEF_W-1:0] H2 =  18'sd20000,
   parameter logic signed [COEF_W-1:0] H3 =  18'sd65535
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_data
);

   import fir_sym_pkg::*;

   localparam int unsigned LAT    = PAIRS + 4;      // port edge to output register
   localparam int unsigned MIR_D  = TAPS;           // mirrored-sample delay line depth
   localparam int unsigned RUN_W  = 5;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;
   localparam logic signed [COEF_W-1:0] COEFS [PAIRS] = '{H0, H1, H2, H3};

   // Elaboration-time parameter checks.
   generate
      if (ACC_W < min_acc_w(DATA_W, COEF_W)) begin : g_bad_acc
         $error("fir_sym8: ACC_W too narrow for full precision");
      end
      if (DATA_W + 1 > 25) begin : g_bad_pre
         $error("fir_sym8: pre-adder result exceeds 25 bits");
      end
      if (COEF_W > 18) begin : g_bad_coef
         $error("fir_sym8: coefficient exceeds 18 bits");
      end
   endgenerate

   // Input register with gating of samples whose strobe is low.
   logic signed [DATA_W-1:0] x_gated, x_q;
   logic                     v_q;

   assign x_gated = in_valid ? $signed(in_data) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         v_q <= 1'b0;
      end else begin
         x_q <= x_gated;
         v_q <= in_valid;
      end
   end

   // Mirrored-sample delay line shared by the pre-adders.
   logic [DATA_W-1:0] mir_raw;
   logic signed [DATA_W-1:0] mir_x;

   fir_sym_shreg #(.W(DATA_W), .DEPTH(MIR_D)) u_mirror (
      .clk (clk),
      .rst (rst),
      .d   (x_q),
      .q   (mir_raw)
   );
   assign mir_x = $signed(mir_raw);

   // Strobe pipeline matched to the data latency.
   logic vld_raw;

   fir_sym_shreg #(.W(1), .DEPTH(LAT)) u_vld (
      .clk (clk),
      .rst (rst),
      .d   (v_q),
      .q   (vld_raw)
   );

   // Systolic cascade of pre-add / multiply / accumulate stages.
   logic signed [DATA_W-1:0] fwd_w [PAIRS+1];
   logic signed [ACC_W-1:0]  acc_w [PAIRS+1];

   assign fwd_w[0] = x_q;
   assign acc_w[0] = '0;

   generate
      for (genvar g = 0; g < PAIRS; g++) begin : g_stage
         fir_sym_stage #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W),
            .COEF   (COEFS[g])
         ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .fwd_in  (fwd_w[g]),
            .mir_in  (mir_x),
            .acc_in  (acc_w[g]),
            .fwd_out (fwd_w[g+1]),
            .acc_out (acc_w[g+1])
         );
      end
   endgenerate

   logic [DATA_W-1:0] unused_fwd;
   assign unused_fwd = fwd_w[PAIRS];

   // Output register.
   logic signed [ACC_W-1:0] y_q;

   always_ff @(posedge clk) begin
      if (rst) y_q <= '0;
      else     y_q <= acc_w[PAIRS];
   end

   assign out_data  = y_q;
   assign out_valid = vld_raw;

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   logic [RUN_W-1:0] live_cnt;   // cycles since reset, saturating
   logic [RUN_W-1:0] idle_run;   // consecutive gated (zero) samples

   always_ff @(posedge clk) begin
      if (rst) begin
         live_cnt <= '0;
         idle_run <= RUN_MAX;
      end else begin
         if (live_cnt != RUN_MAX) live_cnt <= live_cnt + 1'b1;
         if (in_valid)                 idle_run <= '0;
         else if (idle_run != RUN_MAX) idle_run <= idle_run + 1'b1;
      end
   end

   // R1: the cycle after a reset edge shows a cleared output.
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_data == '0 && !out_valid));

   // R4: strobe out is strobe in, eight cycles late.
   a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
      (live_cnt > RUN_W'(LAT)) |-> (out_valid == $past(in_valid, LAT + 1)));

   // R5: a full window of gated samples yields a zero output.
   a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
      ($past(idle_run, LAT) >= RUN_W'(TAPS)) |-> (out_data == '0));

endmodule

// File: tb/tb_fir_sym8.sv
module tb_fir_sym8;

   localparam int DW = 16;
   localparam int CW = 18;
   localparam int AW = 38;
   localparam logic signed [CW-1:0] C0 =  18'sd3;
   localparam logic signed [CW-1:0] C1 = -18'sd77;
   localparam logic signed [CW-1:0] C2 =  18'sd1021;
   localparam logic signed [CW-1:0] C3 = -18'sd131072;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [AW-1:0] out_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   longint hx [16];
   bit     hv [16];

   always #4 clk = ~clk;

   fir_sym8 #(
      .DATA_W (DW), .COEF_W (CW), .ACC_W (AW),
      .H0 (C0), .H1 (C1), .H2 (C2), .H3 (C3)
   ) dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   function automatic longint coef(input int k);
      int m;
      m = (k < 4) ? k : 7 - k;
      case (m)
         0:       return longint'(C0);
         1:       return longint'(C1);
         2:       return longint'(C2);
         default: return longint'(C3);
      endcase
   endfunction

   function automatic longint expect_y();
      longint s = 0;
      for (int k = 0; k < 8; k++) s += coef(k) * hx[8 + k];
      return s;
   endfunction

   task automatic clear_hist();
      for (int i = 0; i < 16; i++) begin
         hx[i] = 0;
         hv[i] = 1'b0;
      end
   endtask

   task automatic push(input bit v, input logic [DW-1:0] d);
      for (int i = 15; i > 0; i--) begin
         hx[i] = hx[i-1];
         hv[i] = hv[i-1];
      end
      hx[0] = v ? longint'($signed(d)) : 0;
      hv[0] = v;
   endtask

   task automatic check_out(input string tag);
      longint got, exp;
      got = longint'($signed(out_data));
      exp = expect_y();
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s out_data actual=%0d expected=%0d", tag, got, exp);
      end
      n_cmp++;
      if (out_valid !== hv[8]) begin
         n_bad++;
         $display("FAIL R4 out_valid actual=%0b expected=%0b", out_valid, hv[8]);
      end
   endtask

   task automatic step(input bit v, input logic [DW-1:0] d, input string tag);
      in_valid = v;
      in_data  = d;
      @(posedge clk);
      push(v, d);
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic check_reset(input string tag);
      n_cmp++;
      if (out_data !== '0 || out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL %s reset actual=%0d/%0b expected=0/0", tag,
                  $signed(out_data), out_valid);
      end
   endtask

   function automatic logic [DW-1:0] full_scale(input longint c, input bit flip);
      bit pos;
      pos = (c >= 0) ^ flip;
      return pos ? 16'sh7fff : 16'sh8000;
   endfunction

   initial begin
      clear_hist();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset("R1");
      rst = 1'b0;

      // R2: unit impulse, then a run of zero samples
      step(1'b1, 16'd1, "R2");
      for (int i = 0; i < 18; i++) step(1'b1, 16'd0, "R2");

      // R2: negative full-scale impulse
      step(1'b1, 16'sh8000, "R2");
      for (int i = 0; i < 18; i++) step(1'b0, 16'd0, "R2");

      // R3: back-to-back random samples
      for (int i = 0; i < 400; i++) step(1'b1, DW'($urandom), "R3");

      // R5 / R4: random strobe gaps with non-zero data under a low strobe
      for (int i = 0; i < 400; i++) begin
         bit v;
         v = ($urandom % 3) != 0;
         step(v, DW'($urandom) | 16'h0001, "R5");
      end
      for (int i = 0; i < 20; i++) step(1'b0, 16'h7fff, "R5");

      // R6: sign-matched full scale, reversed, and constant most-negative
      for (int i = 0; i < 64; i++) step(1'b1, full_scale(coef(7 - (i % 8)), 1'b0), "R6");
      for (int i = 0; i < 64; i++) step(1'b1, full_scale(coef(7 - (i % 8)), 1'b1), "R6");
      for (int i = 0; i < 24; i++) step(1'b1, 16'sh8000, "R6");
      for (int i = 0; i < 24; i++) step(1'b1, 16'sh7fff, "R6");

      // R1: reset in mid-stream clears history
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b1;
      in_data  = 16'd1234;
      @(posedge clk);
      @(negedge clk);
      check_reset("R1");
      clear_hist();
      rst = 1'b0;
      for (int i = 0; i < 20; i++) step(1'b1, DW'($urandom), "R1");

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule